// File: doc/BRIEF.md
# Multiplexed Result Display Scanner

This block drives an eight-digit seven-segment display that has a single shared segment bus and a 3-bit digit select. It takes four unsigned values (a remainder, a quotient, a divisor and a dividend). Each value is split into a ones digit and a tens digit with the shift-and-add-3 method. Each digit is then turned into a segment pattern.

A prescaler produces a scan tick. On each tick a 3-bit slot counter moves to the next digit position. The select and the segment pattern for that position are registered together, so a pattern never appears on the wrong digit. The scan repeats without end. At a high enough tick rate all eight digits look lit at the same time.

Top module: `digit_scan`

## Requirements
- R1: While reset is high, and on the first clock edge after it, `sel_o` is 0 and `seg_o` is 7'b0000000 (all segments off).
- R2: The slot shown by `sel_o` picks the digit: 0 remainder ones, 1 remainder tens, 2 quotient ones, 3 quotient tens, 4 divisor ones, 5 divisor tens, 6 dividend ones, 7 dividend tens.
- R3: `sel_o` changes only by stepping up by one, and it wraps from 7 to 0.
- R4: The slot advances once every `PRESCALE` clock cycles. Counting from the release of reset, the first advance happens on the `PRESCALE`-th rising edge.
- R5: Segment patterns are active high, with bit 6 as segment a and bit 0 as segment g. The digits 0 to 9 are 1111110, 0110000, 1101101, 1111001, 0110011, 1011011, 1011111, 1110000, 1111111, 1111011. A code above 9 gives all segments off.
- R6: A value above 99 shows only its two lowest decimal digits (for example, 255 shows 5 and 5).
- R7: `seg_o` and `sel_o` are registered on the same edge. `seg_o` always carries the pattern for the slot in `sel_o`, computed from the inputs sampled on that edge. An input change therefore appears one cycle later, even while the slot does not move.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rem_i | input | VAL_W | Remainder value |
| quo_i | input | VAL_W | Quotient value |
| dvs_i | input | VAL_W | Divisor value |
| dvd_i | input | VAL_W | Dividend value |
| seg_o | output | 7 | Segment pattern, bit 6 = a, active high |
| sel_o | output | 3 | Digit select (slot number) |

## Verification
The bench first holds all four values at zero, which makes every slot show the same pattern and tests only the scan timing. It then sets four distinct two-digit values, so a swapped slot or a swapped ones/tens digit shows up as a wrong pattern. Values above 99, such as 255, 199 and 100, test that the hundreds digit is dropped. A sweep from 0 to 255 that changes the inputs in the middle of a slot covers every digit code and the one-cycle update latency. A reference model predicts the select and the pattern on every cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;
    localparam int SEG_W  = 7;
    localparam int BCD_W  = 4;
    localparam int NVAL   = 4;
    localparam int SLOTS  = 2 * NVAL;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef logic [BCD_W-1:0]  bcd_t;
    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [SLOT_W-1:0] slot_t;

    // Segment pattern for the idle state (every segment dark).
    localparam seg_t SEG_OFF = '0;
endpackage

// File: rtl/scan_tick.sv
module scan_tick #(
    parameter int PRESCALE = 1000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    generate
        if (PRESCALE <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(PRESCALE);
            localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (cnt_q == LAST) cnt_d = '0;
                else               cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) cnt_q <= '0;
                else     cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/bin_to_bcd.sv
module bin_to_bcd
    import scan_pkg::*;
#(
    parameter int VAL_W = 8
) (
    input  logic [VAL_W-1:0] bin_i,
    output bcd_t             ones_o,
    output bcd_t             tens_o
);
    // Enough decimal digits to hold any VAL_W-bit value.
    localparam int ND = VAL_W / 3 + 1;

    logic [ND*BCD_W-1:0] acc;

    // Shift-and-add-3: fix up each digit before each shift.
    always_comb begin
        acc = '0;
        for (int b = VAL_W - 1; b >= 0; b--) begin
            for (int d = 0; d < ND; d++) begin
                if (acc[d*BCD_W +: BCD_W] > 4'd4)
                    acc[d*BCD_W +: BCD_W] = acc[d*BCD_W +: BCD_W] + 4'd3;
            end
            acc = {acc[ND*BCD_W-2:0], bin_i[b]};
        end
    end

    assign ones_o = acc[0     +: BCD_W];
    assign tens_o = acc[BCD_W +: BCD_W];
endmodule

// File: rtl/seg_encoder.sv
module seg_encoder
    import scan_pkg::*;
(
    input  bcd_t code_i,
    output seg_t seg_o
);
    // Bit 6 is segment a, bit 0 is segment g; a 1 lights the segment.
    always_comb begin
        unique case (code_i)
            4'd0:    seg_o = 7'b1111110;
            4'd1:    seg_o = 7'b0110000;
            4'd2:    seg_o = 7'b1101101;
            4'd3:    seg_o = 7'b1111001;
            4'd4:    seg_o = 7'b0110011;
            4'd5:    seg_o = 7'b1011011;
            4'd6:    seg_o = 7'b1011111;
            4'd7:    seg_o = 7'b1110000;
            4'd8:    seg_o = 7'b1111111;
            4'd9:    seg_o = 7'b1111011;
            default: seg_o = SEG_OFF;
        endcase
    end
endmodule

// File: rtl/digit_scan.sv
module digit_scan
    import scan_pkg::*;
#(
    parameter int VAL_W    = 8,
    parameter int PRESCALE = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VAL_W-1:0] rem_i,
    input  logic [VAL_W-1:0] quo_i,
    input  logic [VAL_W-1:0] dvs_i,
    input  logic [VAL_W-1:0] dvd_i,
    output logic [6:0]       seg_o,
    output logic [2:0]       sel_o
);
    typedef struct packed {
        slot_t slot;
        seg_t  seg;
    } scan_st_t;

    scan_st_t st_d, st_q;

    logic tick;
    logic [VAL_W-1:0] vals [NVAL];
    bcd_t ones [NVAL];
    bcd_t tens [NVAL];
    bcd_t pick;
    seg_t pat;

    // Value order follows the slot map: lowest slots show the remainder.
    assign vals[0] = rem_i;
    assign vals[1] = quo_i;
    assign vals[2] = dvs_i;
    assign vals[3] = dvd_i;

    scan_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    generate
        for (genvar v = 0; v < NVAL; v++) begin : g_conv
            bin_to_bcd #(.VAL_W(VAL_W)) u_bcd (
                .bin_i  (vals[v]),
                .ones_o (ones[v]),
                .tens_o (tens[v])
            );
        end
    endgenerate

    seg_encoder u_enc (
        .code_i (pick),
        .seg_o  (pat)
    );

    always_comb begin
        st_d      = st_q;
        st_d.slot = tick ? slot_t'(st_q.slot + 1'b1) : st_q.slot;
        // Slot bit 0 picks tens, upper bits pick the value.
        pick = st_d.slot[0] ? tens[st_d.slot[SLOT_W-1:1]]
                            : ones[st_d.slot[SLOT_W-1:1]];
        st_d.seg  = pat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.slot <= '0;
            st_q.seg  <= SEG_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_o = st_q.seg;
    assign sel_o = st_q.slot;
endmodule

// File: rtl/digit_scan_chk.sv
module digit_scan_chk #(
    parameter int VAL_W    = 8,
    parameter int PRESCALE = 1000
) (
    input logic             clk,
    input logic             rst,
    input logic [VAL_W-1:0] rem_i,
    input logic [VAL_W-1:0] quo_i,
    input logic [VAL_W-1:0] dvs_i,
    input logic [VAL_W-1:0] dvd_i,
    input logic [6:0]       seg_o,
    input logic [2:0]       sel_o
);
    logic [4*VAL_W-1:0] all_vals;
    assign all_vals = {rem_i, quo_i, dvs_i, dvd_i};

    // Cycles the select has stayed unchanged (saturating).
    int unsigned held_q;
    logic [2:0]  sel_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q     <= 0;
            sel_prev_q <= '0;
        end else begin
            sel_prev_q <= sel_o;
            if (sel_o != sel_prev_q)  held_q <= 0;
            else if (held_q < 32'hFFFF) held_q <= held_q + 1;
        end
    end

    // R1
    p_reset_blank_r1: assert property (@(posedge clk)
        rst |=> (sel_o == 3'd0 && seg_o == 7'd0));

    // R3
    p_sel_step_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_o) |-> sel_o == 3'($past(sel_o) + 3'd1));

    // R4
    p_sel_dwell_r4: assert property (@(posedge clk) disable iff (rst)
        (sel_o != sel_prev_q) |-> held_q >= PRESCALE - 1);

    // R7
    p_seg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ($stable(sel_o) && $past($stable(all_vals)) && !$past(rst, 2))
            |-> $stable(seg_o));
endmodule

bind digit_scan digit_scan_chk #(.VAL_W(VAL_W), .PRESCALE(PRESCALE)) u_chk (.*);

// File: tb/sim_digit_scan.sv
module sim_digit_scan;
    localparam int CLK_PERIOD = 10;
    localparam int VW         = 8;
    localparam int PS         = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [VW-1:0] rem_v = '0, quo_v = '0, dvs_v = '0, dvd_v = '0;
    logic [6:0]    seg;
    logic [2:0]    sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit live   = 1'b0;

    // Reference model state
    int m_cnt  = 0;
    int m_slot = 0;
    int m_seg  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    digit_scan #(.VAL_W(VW), .PRESCALE(PS)) u0 (
        .clk(clk), .rst(rst),
        .rem_i(rem_v), .quo_i(quo_v), .dvs_i(dvs_v), .dvd_i(dvd_v),
        .seg_o(seg), .sel_o(sel)
    );

    function automatic int pat(input int d);
        case (d)
            0: return 7'b1111110;  1: return 7'b0110000;
            2: return 7'b1101101;  3: return 7'b1111001;
            4: return 7'b0110011;  5: return 7'b1011011;
            6: return 7'b1011111;  7: return 7'b1110000;
            8: return 7'b1111111;  9: return 7'b1111011;
            default: return 0;
        endcase
    endfunction

    function automatic int slot_digit(input int s);
        int v;
        case (s / 2)
            0: v = rem_v;
            1: v = quo_v;
            2: v = dvs_v;
            default: v = dvd_v;
        endcase
        return (s % 2) ? (v / 10) % 10 : v % 10;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, advanced on every rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_slot = 0; m_seg = 0;
        end else begin
            if (m_cnt == PS - 1) begin
                m_cnt  = 0;
                m_slot = (m_slot + 1) % 8;
            end else begin
                m_cnt++;
            end
            m_seg = pat(slot_digit(m_slot));
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (live && !done) begin
            check("R3/R4 select", sel, m_slot);
            check("R2/R5/R6/R7 segments", seg, m_seg);
        end
    end

    task automatic set_vals(input int a, input int b, input int c, input int d);
        rem_v = VW'(a); quo_v = VW'(b); dvs_v = VW'(c); dvd_v = VW'(d);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset select", sel, 0);
        check("R1 reset segments", seg, 0);
        rst = 1'b0;
        live = 1'b1;

        // All-zero values: only scan timing matters.
        repeat (40) @(negedge clk);

        // Distinct two-digit values expose slot or digit swaps (R2).
        set_vals(12, 34, 56, 78);
        repeat (48) @(negedge clk);

        // Values above 99 keep only the two low digits (R6).
        set_vals(199, 100, 250, 255);
        while (sel != 3'd7) @(negedge clk);
        @(negedge clk);
        check("R6 dividend tens of 255", seg, 7'b1011011);
        repeat (40) @(negedge clk);

        // Sweep with mid-slot updates covers every digit code (R5, R7).
        for (int v = 0; v < 256; v++) begin
            set_vals(v, 255 - v, (v * 7) % 256, (v + 50) % 256);
            repeat (5) @(negedge clk);
        end

        // Reset again mid-scan (R1).
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-scan select", sel, 0);
        check("R1 reset mid-scan segments", seg, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);

        done = 1'b1;
        finish_run();
    end
endmodule